// File: doc/BRIEF.md
# Parallel Fixed-Point Neuron Datapath

This block evaluates one artificial neuron in two's-complement fixed point. In every cycle it takes a lane-parallel vector of inputs and a matching vector of weights. It forms all lane products at once and reduces them through a balanced adder tree. When the caller asserts `enable`, the reduced value is added into a wide accumulation register. A long dot product can therefore be fed in over several beats, `LANES` terms at a time.

When the caller asserts `activ`, the block aligns the bias to the product scale and adds it to the accumulated value. It then rescales the result to the data format, saturates it, and passes it through one of two activations chosen per request:

- a rectifier;
- a sigmoid-shaped curve held in a small constant table.

The result is registered and held until the next activation request. A surrounding controller owns the weight storage and the beat sequencing. It pulses `clear` at the start of each neuron and issues the enable beats. It then pulses `activ` once and collects `y` one cycle later.

Top module: `fxp_neuron`

## Requirements
- R1: While `rst_n` is low, the accumulator and `y` are zero. After reset, with no activation request, `y` reads 0.
- R2: On every rising edge with `enable` high, the accumulator gains the exact sum over all lanes of x[i]*w[i]. Lane i occupies bits [i*DW +: DW] of each vector, and every value is DW-bit two's complement.
- R3: `clear` high with `enable` low sets the accumulator to zero. `clear` and `enable` high together load the accumulator with only the current beat's lane sum.
- R4: `y` changes only on a rising edge where `activ` is high. At all other times it holds its last value, whatever the other inputs do.
- R5: x, w and bias carry FRAC fraction bits, so products carry 2*FRAC. The pre-activation value is floor((acc + bias*2^FRAC) / 2^FRAC).
- R6: The pre-activation value is saturated to the range [-2^(DW-1), 2^(DW-1)-1] before the activation is applied.
- R7: With `act_sel` = 0, `y` = max(0, s), where s is the saturated pre-activation value.
- R8: With `act_sel` = 1, the index is k = floor(s / 2^(FRAC-2)), clipped to [-2^(LUT_BITS-1), 2^(LUT_BITS-1)-1]. The output is y = H + trunc(H*k / (4+|k|)), with H = 2^(FRAC-1) and the division truncating toward zero.
- R9: The accumulator does not overflow over MAX_BEATS beats of any inputs, including the most extreme products, when counted from a `clear`.
- R10: When `activ` and `enable` are high in the same cycle, `y` is computed from the accumulator value before that beat is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start a new accumulation |
| enable | input | 1 | Add the current lane sum to the accumulator |
| activ | input | 1 | Apply bias and activation, then register the output |
| act_sel | input | 1 | 0 = rectifier, 1 = table sigmoid |
| x_vec | input | LANES*DW | Packed lane inputs |
| w_vec | input | LANES*DW | Packed lane weights |
| bias | input | DW | Bias, same format as the inputs |
| y | output | DW | Registered activation result |

## Verification
The bench builds the block with its defaults: four lanes, 10-bit data with five fraction bits, 64 beats and a 32-entry table.

With these values, products of the most negative operands give sums large enough to test positive saturation and the full 64-beat overflow margin. The table index can be driven to both clip ends, and a zero pre-activation lands on the midpoint entry.

Random multi-beat sums with random bias and mode cover the rescaling floor on both signs. Directed cases cover:
- a clear cycle alone, and clear together with enable;
- activation in the same cycle as an enable beat;
- idle cycles in which `y` must hold.

// File: rtl/fxp_neuron_pkg.sv
package fxp_neuron_pkg;

   typedef enum logic {
      ACT_RELU = 1'b0,
      ACT_SIGM = 1'b1
   } act_sel_e;

   // Sigmoid-like level for table slot k: half + trunc(half*k/(knee+|k|))
   function automatic integer sig_level(input integer k, input integer half, input integer knee);
      integer mag;
      mag = (k < 0) ? -k : k;
      return half + (half * k) / (knee + mag);
   endfunction

endpackage

// File: rtl/fxp_mult_array.sv
module fxp_mult_array #(
   parameter int LANES = 4,
   parameter int DW    = 10
) (
   input  logic [LANES*DW-1:0]   x_vec,
   input  logic [LANES*DW-1:0]   w_vec,
   output logic [LANES*2*DW-1:0] p_vec
);
   localparam int PW = 2 * DW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [DW-1:0] xa;
      logic signed [DW-1:0] wa;
      logic signed [PW-1:0] pr;
      assign xa = x_vec[g*DW +: DW];
      assign wa = w_vec[g*DW +: DW];
      assign pr = PW'(xa) * PW'(wa);
      assign p_vec[g*PW +: PW] = pr;
   end

endmodule

// File: rtl/fxp_adder_tree.sv
module fxp_adder_tree #(
   parameter int LANES = 4,
   parameter int IW    = 20,
   localparam int LV   = $clog2(LANES),
   localparam int P    = 1 << LV,
   localparam int OW   = IW + LV
) (
   input  logic [LANES*IW-1:0] in_vec,
   output logic signed [OW-1:0] total
);

   for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
      localparam int W = P >> lv;
      logic signed [OW-1:0] s [W];
      for (genvar i = 0; i < W; i++) begin : g_n
         if (lv == 0) begin : g_leaf
            if (i < LANES) begin : g_used
               logic signed [IW-1:0] leaf;
               assign leaf = in_vec[i*IW +: IW];
               assign s[i] = OW'(leaf);
            end else begin : g_pad
               assign s[i] = '0;
            end
         end else begin : g_add
            assign s[i] = g_lvl[lv-1].s[2*i] + g_lvl[lv-1].s[2*i+1];
         end
      end
   end

   assign total = g_lvl[LV].s[0];

endmodule

// File: rtl/fxp_saturate.sv
module fxp_saturate #(
   parameter int IW = 30,
   parameter int OW = 10
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);
   localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (OW - 1)) - 64'sd1);
   localparam logic signed [IW-1:0] LO = -HI - IW'(1);

   always_comb begin
      if (din > HI)
         dout = HI[OW-1:0];
      else if (din < LO)
         dout = LO[OW-1:0];
      else
         dout = din[OW-1:0];
   end

endmodule

// File: rtl/fxp_activation.sv
module fxp_activation
   import fxp_neuron_pkg::*;
#(
   parameter int DW       = 10,
   parameter int FRAC     = 5,
   parameter int SW       = 28,
   parameter int LUT_BITS = 5
) (
   input  logic signed [SW-1:0] acc,
   input  logic signed [DW-1:0] bias,
   input  logic                 act_sel,
   output logic [DW-1:0]        y
);
   localparam int XW        = SW + 1;
   localparam int SIG_SHIFT = FRAC - 2;
   localparam int KNEE      = 4;
   localparam int HALF      = 1 << (FRAC - 1);
   localparam int DEPTH     = 1 << LUT_BITS;
   localparam int KL        = DEPTH / 2;
   localparam logic signed [DW-1:0] K_HI = DW'(KL - 1);
   localparam logic signed [DW-1:0] K_LO = DW'(-KL);

   logic signed [XW-1:0] pre_full;
   logic signed [XW-1:0] pre_q;
   logic signed [DW-1:0] sat;

   assign pre_full = XW'(acc) + (XW'(bias) <<< FRAC);
   assign pre_q    = pre_full >>> FRAC;

   fxp_saturate #(.IW(XW), .OW(DW)) sat_i (
      .din  (pre_q),
      .dout (sat)
   );

   // rectifier
   logic [DW-1:0] relu_y;
   assign relu_y = sat[DW-1] ? '0 : sat;

   // table sigmoid
   logic signed [DW-1:0] k_raw;
   logic signed [DW-1:0] k_clip;
   logic signed [DW-1:0] k_off;
   logic [LUT_BITS-1:0]  idx;
   logic [DW-1:0]        rom [DEPTH];

   assign k_raw = sat >>> SIG_SHIFT;

   always_comb begin
      if (k_raw > K_HI)
         k_clip = K_HI;
      else if (k_raw < K_LO)
         k_clip = K_LO;
      else
         k_clip = k_raw;
   end

   assign k_off = k_clip + DW'(KL);
   assign idx   = k_off[LUT_BITS-1:0];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = DW'(sig_level(g - KL, HALF, KNEE));
   end

   assign y = (act_sel == ACT_SIGM) ? rom[idx] : relu_y;

endmodule

// File: rtl/fxp_neuron.sv
module fxp_neuron #(
   parameter int LANES     = 4,
   parameter int DW        = 10,
   parameter int FRAC      = 5,
   parameter int MAX_BEATS = 64,
   parameter int LUT_BITS  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                enable,
   input  logic                activ,
   input  logic                act_sel,
   input  logic [LANES*DW-1:0] x_vec,
   input  logic [LANES*DW-1:0] w_vec,
   input  logic [DW-1:0]       bias,
   output logic [DW-1:0]       y
);
   localparam int PW = 2 * DW;
   localparam int LV = $clog2(LANES);
   localparam int TW = PW + LV;
   localparam int SW = TW + $clog2(MAX_BEATS);

   // elaboration-time parameter checks
   if (LANES < 2) begin : g_chk_lanes
      $error("fxp_neuron: LANES must be at least 2");
   end
   if (DW < 4) begin : g_chk_dw
      $error("fxp_neuron: DW must be at least 4");
   end
   if (FRAC < 2 || FRAC >= DW) begin : g_chk_frac
      $error("fxp_neuron: FRAC must lie in [2, DW-1]");
   end
   if (LUT_BITS < 2 || LUT_BITS > DW || LUT_BITS > 6) begin : g_chk_lut
      $error("fxp_neuron: LUT_BITS must lie in [2, min(DW,6)]");
   end
   if (MAX_BEATS < 2) begin : g_chk_beats
      $error("fxp_neuron: MAX_BEATS must be at least 2");
   end

   logic [LANES*PW-1:0]  prod_vec;
   logic signed [TW-1:0] tree_sum;
   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] sum_base;
   logic [DW-1:0]        act_y;
   logic [DW-1:0]        y_q;

   fxp_mult_array #(.LANES(LANES), .DW(DW)) mult_i (
      .x_vec (x_vec),
      .w_vec (w_vec),
      .p_vec (prod_vec)
   );

   fxp_adder_tree #(.LANES(LANES), .IW(PW)) tree_i (
      .in_vec (prod_vec),
      .total  (tree_sum)
   );

   assign sum_base = clear ? '0 : sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sum_q <= '0;
      else if (enable)
         sum_q <= sum_base + SW'(tree_sum);
      else if (clear)
         sum_q <= '0;
   end

   fxp_activation #(.DW(DW), .FRAC(FRAC), .SW(SW), .LUT_BITS(LUT_BITS)) act_i (
      .acc     (sum_q),
      .bias    (bias),
      .act_sel (act_sel),
      .y       (act_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         y_q <= '0;
      else if (activ)
         y_q <= act_y;
   end

   assign y = y_q;

endmodule

// File: rtl/fxp_neuron_chk.sv
module fxp_neuron_chk #(
   parameter int DW        = 10,
   parameter int FRAC      = 5,
   parameter int SW        = 28,
   parameter int MAX_BEATS = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clear,
   input logic                 enable,
   input logic                 activ,
   input logic                 act_sel,
   input logic [DW-1:0]        y,
   input logic signed [SW-1:0] sum_q
);
   localparam int CW = $clog2(MAX_BEATS + 2) + 1;
   localparam logic [DW-1:0] ONE = DW'(1 << FRAC);

   logic [CW-1:0] beat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_cnt <= '0;
      else if (clear)
         beat_cnt <= enable ? CW'(1) : '0;
      else if (enable && beat_cnt <= CW'(MAX_BEATS))
         beat_cnt <= beat_cnt + CW'(1);
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !activ |=> $stable(y));

   assert_relu_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (activ && !act_sel) |=> !y[DW-1]);

   assert_sig_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (activ && act_sel) |=> (y <= ONE));

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !enable) |=> (sum_q == '0));

   assert_beat_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
      beat_cnt <= CW'(MAX_BEATS));

endmodule

bind fxp_neuron fxp_neuron_chk #(
   .DW        (DW),
   .FRAC      (FRAC),
   .SW        (SW),
   .MAX_BEATS (MAX_BEATS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .clear   (clear),
   .enable  (enable),
   .activ   (activ),
   .act_sel (act_sel),
   .y       (y),
   .sum_q   (sum_q)
);

// File: tb/fxp_neuron_tb_top.sv
module fxp_neuron_tb_top;
   localparam int LANES     = 4;
   localparam int DW        = 10;
   localparam int FRAC      = 5;
   localparam int MAX_BEATS = 64;
   localparam int LUT_BITS  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0, enable = 1'b0, activ = 1'b0, act_sel = 1'b0;
   logic signed [DW-1:0] xs [LANES];
   logic signed [DW-1:0] ws [LANES];
   logic [LANES*DW-1:0]  x_vec, w_vec;
   logic [DW-1:0]        bias = '0;
   logic [DW-1:0]        y;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   longint acc_m = 0;
   int    y_exp = 0;

   always #5 clk = ~clk;

   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign x_vec[g*DW +: DW] = xs[g];
      assign w_vec[g*DW +: DW] = ws[g];
   end

   fxp_neuron #(
      .LANES(LANES), .DW(DW), .FRAC(FRAC), .MAX_BEATS(MAX_BEATS), .LUT_BITS(LUT_BITS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable), .activ(activ),
      .act_sel(act_sel), .x_vec(x_vec), .w_vec(w_vec), .bias(bias), .y(y)
   );

   function automatic longint lane_sum();
      longint s = 0;
      for (int i = 0; i < LANES; i++) s += longint'(xs[i]) * longint'(ws[i]);
      return s;
   endfunction

   function automatic int model_y(longint acc, logic signed [DW-1:0] b, bit sel);
      longint pre, hi, lo, s, k, kl, half;
      pre = (acc + longint'(b) * (longint'(1) << FRAC)) >>> FRAC;
      hi = (longint'(1) << (DW - 1)) - 1;
      lo = -hi - 1;
      s = (pre > hi) ? hi : (pre < lo) ? lo : pre;
      if (!sel) return (s < 0) ? 0 : int'(s);
      kl = longint'(1) << (LUT_BITS - 1);
      half = longint'(1) << (FRAC - 1);
      k = s >>> (FRAC - 2);
      if (k > kl - 1) k = kl - 1;
      if (k < -kl) k = -kl;
      return int'(half + (half * k) / (4 + ((k < 0) ? -k : k)));
   endfunction

   task automatic check(string req, int act, int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // one clock: apply controls, model, step, check
   task automatic cyc(bit en, bit clr, bit act, bit sel, string req);
      enable = en; clear = clr; activ = act; act_sel = sel;
      if (act) y_exp = model_y(acc_m, bias, sel);
      if (en) acc_m = (clr ? 0 : acc_m) + lane_sum();
      else if (clr) acc_m = 0;
      @(posedge clk); #1;
      enable = 1'b0; clear = 1'b0; activ = 1'b0;
      check(req, int'(y), y_exp);
   endtask

   task automatic rand_lanes();
      for (int i = 0; i < LANES; i++) begin
         xs[i] = DW'($urandom);
         ws[i] = DW'($urandom);
      end
   endtask

   task automatic set_lanes(int xv, int wv);
      for (int i = 0; i < LANES; i++) begin
         xs[i] = DW'(xv);
         ws[i] = DW'(wv);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      set_lanes(0, 0);
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset y", int'(y), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after reset", int'(y), 0);

      // R3: clear alone, then bias-only rectifier
      bias = DW'(5);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, "R3 clear hold");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R3 bias only R7");
      // midpoint of table
      bias = DW'(0);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8 midpoint");

      // R3: clear with enable keeps only current beat
      rand_lanes(); cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 hold");
      rand_lanes(); cyc(1'b1, 1'b0, 1'b0, 1'b0, "R4 hold");
      set_lanes(3, 7); cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 hold");
      bias = DW'(-2);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R3 clear+enable R5");

      // R10: activ and enable together use old sum
      set_lanes(100, 100);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, "R10 same cycle");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R10 after beat");

      // R6 positive saturation and R8 upper clip
      bias = DW'(0);
      set_lanes(-512, -512);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 hold");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, "R4 hold");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6 sat high");
      check("R6 sat high value", int'(y), 511);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8 clip high");

      // negative saturation: rectifier zero, table lower clip
      set_lanes(511, -512);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 hold");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6 sat low R7");
      cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8 clip low");
      check("R8 clip low value", int'(y), 4);

      // R9: full beat budget with the largest positive products
      set_lanes(-512, -512);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, "R9 hold");
      for (int b = 1; b < MAX_BEATS; b++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R9 hold");
      bias = DW'(-512);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R9 no overflow");
      check("R9 no overflow value", int'(y), 511);

      // random multi-beat neurons
      for (int t = 0; t < 60; t++) begin
         int nb;
         nb = 1 + int'($urandom % 8);
         for (int b = 0; b < nb; b++) begin
            rand_lanes();
            cyc(1'b1, (b == 0), 1'b0, 1'b0, "R2 R4 hold");
         end
         bias = DW'($urandom);
         rand_lanes();
         cyc(1'b0, 1'b0, 1'b1, $urandom % 2 == 1, "R2 R5 random");
         rand_lanes();
         cyc(1'b0, 1'b0, 1'b0, 1'b0, "R4 idle hold");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule